// File: doc/BRIEF.md
# Serial Time-Slot Switch

This block moves 8-bit samples between serial PCM streams. Sixteen input lines and sixteen output lines share one bit-rate clock and one frame sync. Each frame lasts 1024 clocks. Every input byte is captured into an inferred data memory. A connection memory, written through a simple address/data strobe, decides for each output slot which input stream and slot it carries. It also says whether the byte is taken with the least possible delay or held back so that all slots of a wideband channel leave in the same frame.

Each stream index has its own rate code. The input line and the output line with that index both follow it, so a 2 Mbit/s stream can feed an 8 Mbit/s stream and the reverse. The data memory has two banks that swap at every frame boundary. Frame-integrity reads always take the bank that was filled during the previous frame. Minimum-latency reads take the newest copy of the source byte. A byte that completes on the very clock it is needed is forwarded straight from the capture path.

Top module: `slot_switch`

## Requirements
- R1: While reset is held and after it is released, every output line is high, every connection entry is disabled and every stream's rate code is 2.
- R2: The clock in which `fsync` is high is the first clock of bit 7 of slot 0 on every stream, and the frame is 1024 clocks. Bits go MSB first. Rate code 0, 1 or 2 gives a bit period of 4, 2 or 1 clocks and 32, 64 or 128 slots per frame, and code 3 behaves as code 2. An input bit is sampled on the last clock of its period. An output bit is held for the whole of its period.
- R3: A write with `cfg_addr[11]`=0 stores `cfg_wdata` into the entry for output stream `cfg_addr[10:7]`, slot `cfg_addr[6:0]`. The entry fields are enable in bit 12, minimum-latency select in bit 11 (1 = minimum latency), source stream in bits 10:7 and source slot in bits 6:0. Any input stream and slot can feed any output stream and slot.
- R4: An output slot whose entry has the enable bit clear carries 8'hFF.
- R5: In minimum-latency mode, output slot n of frame F carries the source byte of frame F when the source slot's last clock is at or before the clock just before slot n starts. Otherwise it carries the byte of frame F-1. Output slot 0 always carries frame F-1.
- R6: In frame-integrity mode, output slot n of frame F carries the source byte captured in frame F-1 for every n. This holds for all slots of a multi-slot channel, so they leave together and in order.
- R7: A write with `cfg_addr[11]`=1 sets the rate code of stream `cfg_addr[3:0]` to `cfg_wdata[1:0]`. Streams at different rates can be connected in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (one clock per bit at rate code 2) |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame start marker, high for one clock |
| sin | input | 16 | Serial input lines, one per stream |
| sout | output | 16 | Serial output lines, one per stream |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Bit 11 selects rate table (1) or connection entry (0) |
| cfg_wdata | input | 13 | Connection entry or rate code |

## Verification
The hardest situation to reach is a minimum-latency connection whose source slot ends on exactly the clock on which the output slot is loaded. Only the forwarding path delivers the current frame's byte there, and the frame-end wrap changes which bank is read. Directed entries place source slots one clock and nine clocks before an output slot start, at equal and at different rates. They also build a four-slot wideband channel ending on the frame's last slot. Seeded random connection tables with mixed rates, modes and disabled slots surround these cases, and every output byte of three frames per phase is compared with a bench model.

// File: rtl/slot_switch.sv
module slot_switch #(
  parameter int NSTR = 16,
  parameter int SLOTW = 7,
  localparam int SW = $clog2(NSTR),
  localparam int MW = SW + SLOTW,
  localparam int CAW = MW + 1,
  localparam int CDW = MW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fsync,
  input  logic [NSTR-1:0] sin,
  output logic [NSTR-1:0] sout,
  input  logic            cfg_we,
  input  logic [CAW-1:0]  cfg_addr,
  input  logic [CDW-1:0]  cfg_wdata
);
  localparam int PW = SLOTW + 3;
  localparam int DEPTH = 1 << MW;

  function automatic int shf(input logic [1:0] r);
    return (r >= 2'd2) ? 0 : 2 - int'(r);
  endfunction

  logic [PW-1:0]    cnt_q, pos;
  logic             frame_end, wbank_q;
  logic [1:0]       rate_q [NSTR];
  logic [CDW-1:0]   conn_q [DEPTH];
  logic [7:0]       dmem [2][DEPTH];
  logic [7:0]       sh_q [NSTR];
  logic [7:0]       ob_q [NSTR];
  logic [7:0]       cap_b [NSTR];
  logic [7:0]       nb [NSTR];
  logic [SLOTW-1:0] cap_slot [NSTR];
  logic [NSTR-1:0]  cap_v, bit_end, ld, en, mid;

  assign pos = fsync ? '0 : cnt_q;
  assign frame_end = &pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wbank_q <= 1'b0;
    end else begin
      cnt_q <= pos + 1'b1;
      if (frame_end) wbank_q <= ~wbank_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NSTR; k++) rate_q[k] <= 2'd2;
      for (int d = 0; d < DEPTH; d++) conn_q[d] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr[CAW-1]) rate_q[cfg_addr[SW-1:0]] <= cfg_wdata[1:0];
      else conn_q[cfg_addr[MW-1:0]] <= cfg_wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < NSTR; i++) begin
      int s;
      s = shf(rate_q[i]);
      bit_end[i] = (int'(pos) & ((1 << s) - 1)) == ((1 << s) - 1);
      cap_v[i] = (int'(pos) & ((8 << s) - 1)) == ((8 << s) - 1);
      cap_b[i] = {sh_q[i][6:0], sin[i]};
      cap_slot[i] = SLOTW'(int'(pos) >> (s + 3));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTR; i++) sh_q[i] <= '1;
    end else begin
      for (int i = 0; i < NSTR; i++)
        if (bit_end[i]) sh_q[i] <= {sh_q[i][6:0], sin[i]};
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSTR; i++)
      if (cap_v[i]) dmem[wbank_q][{SW'(i), cap_slot[i]}] <= cap_b[i];
  end

  always_comb begin
    for (int j = 0; j < NSTR; j++) begin
      int so, si, endm;
      logic [SLOTW-1:0] nxt, sl;
      logic [SW-1:0] src;
      logic [CDW-1:0] e;
      logic rb, fwd;
      so = shf(rate_q[j]);
      ld[j] = (int'(pos) & ((8 << so) - 1)) == ((8 << so) - 1);
      mid[j] = (int'(pos) & ((1 << so) - 1)) != 0;
      nxt = SLOTW'((int'(pos) >> (so + 3)) + 1) & SLOTW'((1 << (SLOTW - so)) - 1);
      e = conn_q[{SW'(j), nxt}];
      en[j] = e[CDW-1];
      src = e[MW-1:SLOTW];
      sl = e[SLOTW-1:0];
      si = shf(rate_q[src]);
      endm = ((int'(sl) + 1) << (si + 3)) - 1;
      rb = frame_end ? wbank_q : (e[CDW-2] && endm <= int'(pos)) ? wbank_q : ~wbank_q;
      fwd = (rb == wbank_q) && cap_v[src] && (cap_slot[src] == sl);
      nb[j] = !en[j] ? 8'hFF : fwd ? cap_b[src] : dmem[rb][{src, sl}];
      sout[j] = ob_q[j][3'd7 - 3'((int'(pos) >> so) & 7)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NSTR; j++) ob_q[j] <= 8'hFF;
    end else begin
      for (int j = 0; j < NSTR; j++)
        if (ld[j]) ob_q[j] <= nb[j];
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> sout == '1);

  p_bank_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> wbank_q != $past(wbank_q));

  for (genvar g = 0; g < NSTR; g++) begin : g_chk
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !fsync && $stable(rate_q[g]) && mid[g] |-> sout[g] == $past(sout[g]));

    p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld[g] && !en[g] |=> sout[g]);

    p_capture_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_v[g] |=> dmem[$past(wbank_q)][{SW'(g), $past(cap_slot[g])}] == $past(cap_b[g]));
  end
endmodule

// File: tb/slot_switch_test.sv
module slot_switch_test;
  localparam int NSTR = 16;
  localparam int SLOTW = 7;
  localparam int NS = 1 << SLOTW;
  localparam int FR = 1 << (SLOTW + 3);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, fsync = 1'b0, cfg_we = 1'b0;
  logic [NSTR-1:0] sin = '1;
  logic [NSTR-1:0] sout;
  logic [11:0] cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;

  slot_switch uut (.clk(clk), .rst_n(rst_n), .fsync(fsync), .sin(sin), .sout(sout),
                   .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] inb [4][NSTR][NS];
  logic [1:0] rate_b [NSTR];
  logic [12:0] conn_b [NSTR*NS];

  function automatic int shf(input logic [1:0] r);
    return (r >= 2'd2) ? 0 : 2 - int'(r);
  endfunction

  function automatic int nslots(input int s);
    return 1 << (SLOTW - shf(rate_b[s]));
  endfunction

  function automatic logic [7:0] exp_byte(input int f, input int j, input int n);
    logic [12:0] e;
    int src, m, so, si, st, endm;
    e = conn_b[j*NS + n];
    if (!e[12]) return 8'hFF;
    src = int'(e[10:7]);
    m = int'(e[6:0]);
    if (e[11]) begin
      so = shf(rate_b[j]);
      si = shf(rate_b[src]);
      st = n << (so + 3);
      endm = ((m + 1) << (si + 3)) - 1;
      if (endm <= st - 1) return inb[f][src][m];
    end
    return inb[f-1][src][m];
  endfunction

  task automatic cfg_write(input logic [11:0] a, input logic [12:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_conn(input int j, input int n, input bit en, input bit ml, input int src, input int m);
    conn_b[j*NS + n] = {en, ml, 4'(src), 7'(m)};
    cfg_write({1'b0, 4'(j), 7'(n)}, conn_b[j*NS + n]);
  endtask

  task automatic do_reset();
    bit ok;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < NSTR; i++) rate_b[i] = 2'd2;
    for (int k = 0; k < NSTR*NS; k++) conn_b[k] = '0;
    ok = 1;
    repeat (6) begin
      @(negedge clk);
      if (sout !== '1) ok = 0;
    end
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R1 idle after reset: got %h expected %h", sout, 16'hFFFF);
    end
  endtask

  task automatic setup(input int ph);
    for (int i = 0; i < NSTR; i++) begin
      if (ph == 2) rate_b[i] = 2'($urandom % 3);
      else if (ph == 3 && i == 6) rate_b[i] = 2'd0;
      else if (ph == 3 && i == 7) rate_b[i] = 2'd1;
      else rate_b[i] = 2'd2;
      cfg_write({1'b1, 7'd0, 4'(i)}, {11'd0, rate_b[i]});
    end
    for (int j = 0; j < NSTR; j++)
      for (int n = 0; n < nslots(j); n++) begin
        int src;
        src = int'($urandom % NSTR);
        set_conn(j, n, (ph == 2) ? ($urandom % 6 != 0) : 1'b1, 1'($urandom % 2),
                 src, int'($urandom % nslots(src)));
      end
    if (ph == 3) begin
      for (int k = 0; k < 4; k++) set_conn(0, k, 1, 0, 5, 124 + k);
      set_conn(1, 10, 1, 1, 2, 9);
      set_conn(1, 11, 1, 1, 2, 11);
      set_conn(1, 12, 1, 1, 3, 10);
      set_conn(1, 0, 1, 1, 4, 0);
      set_conn(1, 127, 1, 1, 8, 126);
      set_conn(6, 3, 1, 1, 2, 11);
      set_conn(6, 4, 1, 1, 7, 15);
      set_conn(7, 20, 0, 1, 2, 3);
    end
  endtask

  task automatic run_frames(input string tag);
    logic [7:0] acc [NSTR];
    logic first [NSTR];
    bit bad [NSTR];
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < NSTR; i++)
        for (int s = 0; s < NS; s++) inb[f][i][s] = 8'($urandom);
      for (int p = 0; p < FR; p++) begin
        @(posedge clk); #1;
        fsync = (p == 0);
        for (int i = 0; i < NSTR; i++) begin
          int si;
          si = shf(rate_b[i]);
          sin[i] = inb[f][i][p >> (si + 3)][7 - ((p >> si) & 7)];
        end
        @(negedge clk);
        for (int j = 0; j < NSTR; j++) begin
          int so, bm, sm, n;
          so = shf(rate_b[j]);
          bm = (1 << so) - 1;
          sm = (8 << so) - 1;
          if ((p & sm) == 0) bad[j] = 0;
          if ((p & bm) == 0) first[j] = sout[j];
          else if (sout[j] !== first[j]) bad[j] = 1;
          if ((p & bm) == bm) acc[j] = {acc[j][6:0], first[j]};
          if ((p & sm) == sm && f >= 1) begin
            logic [7:0] ex;
            logic [12:0] e;
            string rq;
            n = p >> (so + 3);
            ex = exp_byte(f, j, n);
            e = conn_b[j*NS + n];
            rq = !e[12] ? "R4" : e[11] ? "R5" : "R6";
            n_chk++;
            if (acc[j] !== ex || bad[j]) begin
              n_fail++;
              $display("FAIL %s/%s%s out %0d slot %0d frame %0d: got %02h expected %02h",
                       rq, tag, bad[j] ? "/R2 unstable bit" : "", j, n, f, acc[j], ex);
            end
          end
        end
      end
    end
    @(posedge clk); #1;
    fsync = 1'b0;
    sin = '1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    setup(1);
    run_frames("R3");
    do_reset();
    setup(2);
    run_frames("R7");
    do_reset();
    setup(3);
    run_frames("R2");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R1..R7 run): got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule